// File: doc/BRIEF.md
# Multi-Word Element Queue with Watermark and Coalescing Timer

This block is a hardware queue with one producer and one consumer. Data travels as elements, and each element is a run-time selected number of 32-bit words. The producer writes the words of an element one at a time, and the consumer reads them back the same way. Occupancy is tracked in whole elements and compared against a run-time depth limit. All words are held in a single synchronous on-chip RAM and addressed through circular word pointers.

Level outputs report the queue state: not-empty, below the low watermark and above the high watermark. They let the consumer decide when to service the queue. A coalescing timer starts when the first element lands in an empty queue. If the high watermark is not exceeded within the programmed number of clock ticks, the timer raises its own level output. This means a trickle of traffic is still serviced promptly, while a burst is serviced once through the high-watermark output.

A small write-only configuration port sets the words per element, the depth, both watermarks and the timeout. The configuration is meant to be changed only while the queue is empty.

Top module: `elem_fifo`

## Requirements
- R1: After reset, `elem_count` is 0, `not_empty`, `lwm_evt`, `hwm_evt`, `tmr_evt`, `push_err`, `pop_err` and `pop_valid` are all 0. The reset configuration is 1 word per element, depth `MAX_DEPTH`, low watermark 0, high watermark `MAX_DEPTH` and timeout 0.
- R2: Each cycle with `push_valid` high stores one word. An element is counted only at the clock edge that stores its last word (word index = words per element − 1). Gaps between words are allowed.
- R3: When `pop_req` is accepted, `pop_valid` and `pop_data` are presented one cycle later, in the order the words were pushed. `pop_last` marks the final word of an element. `elem_count` drops only at the edge where that final word is read.
- R4: A word that would start a new element while `elem_count` equals the depth is discarded and sets the sticky `push_err`. The stored contents and the count are unaffected.
- R5: A `pop_req` while `elem_count` is 0 produces no `pop_valid` and sets the sticky `pop_err`.
- R6: Configuration writes use `cfg_sel` codes 0 = words per element, 1 = depth, 2 = low watermark, 3 = high watermark, 4 = timeout ticks. A words value of 0 or above `MAX_WORDS` is ignored, and so is a depth value of 0 or above `MAX_DEPTH`.
- R7: `lwm_evt` is high exactly while `elem_count` is below the low watermark.
- R8: `hwm_evt` is high exactly while `elem_count` is above the high watermark.
- R9: `not_empty` is high exactly while `elem_count` is nonzero. Both update at the same edge.
- R10: With a nonzero timeout T, `tmr_evt` rises T clock edges after the edge that commits an element into an empty queue. It then stays high until the queue is empty. A timeout of 0 disables the timer.
- R11: If the count exceeds the high watermark at any time before expiry, `tmr_evt` stays low until the queue next becomes empty.
- R12: When the queue becomes empty, the timer and `tmr_evt` clear. The next commit into the empty queue starts a full new interval.
- R13: Word pointers wrap modulo (words per element × depth). Data stays intact across repeated wraps when this span is not a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration field select |
| cfg_wdata | input | TMR_W | Configuration value |
| push_valid | input | 1 | Producer word strobe |
| push_data | input | DATA_W | Producer word |
| pop_req | input | 1 | Consumer word request |
| pop_valid | output | 1 | Popped word valid |
| pop_data | output | DATA_W | Popped word |
| pop_last | output | 1 | Popped word closes its element |
| elem_count | output | clog2(MAX_DEPTH+1) | Committed elements held |
| not_empty | output | 1 | At least one element held |
| lwm_evt | output | 1 | Count below low watermark |
| hwm_evt | output | 1 | Count above high watermark |
| tmr_evt | output | 1 | Coalescing timeout expired |
| push_err | output | 1 | Sticky: a push met a full queue |
| pop_err | output | 1 | Sticky: a pop met an empty queue |

## Verification
The bench targets the element boundary. A design that counts words instead of whole elements shows a nonzero count after a partial push or a premature drop after a partial pop. Rejected pushes into a full queue are followed by a full drain, so a design that wrote them anyway would return the rejected words. A three-word, five-element span forces the pointers through repeated wraps that are not a power of two, which exposes wrap logic that relies on natural overflow. The timer is sampled on the edge before and the edge of expiry, and again after a premature drain and restart. Bursts that cross the high watermark catch a timer that fires regardless of the threshold, and a zero timeout catches one that is never disabled.

// File: rtl/elem_fifo_pkg.sv
package elem_fifo_pkg;
  localparam int CFG_SEL_W = 3;

  typedef enum logic [CFG_SEL_W-1:0] {
    CFG_WORDS   = 3'd0,
    CFG_DEPTH   = 3'd1,
    CFG_LWM     = 3'd2,
    CFG_HWM     = 3'd3,
    CFG_TIMEOUT = 3'd4
  } cfg_sel_e;
endpackage

// File: rtl/elem_fifo_cfg.sv
module elem_fifo_cfg
  import elem_fifo_pkg::*;
#(
  parameter int MAX_WORDS = 4,
  parameter int MAX_DEPTH = 16,
  parameter int TMR_W     = 16
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   we,
  input  logic [CFG_SEL_W-1:0]                   sel,
  input  logic [TMR_W-1:0]                       wdata,
  output logic [$clog2(MAX_WORDS+1)-1:0]         words,
  output logic [$clog2(MAX_DEPTH+1)-1:0]         depth,
  output logic [$clog2(MAX_DEPTH+1)-1:0]         lwm,
  output logic [$clog2(MAX_DEPTH+1)-1:0]         hwm,
  output logic [TMR_W-1:0]                       timeout,
  output logic [$clog2(MAX_WORDS*MAX_DEPTH+1)-1:0] span
);
  localparam int WPE_W  = $clog2(MAX_WORDS+1);
  localparam int CNT_W  = $clog2(MAX_DEPTH+1);
  localparam int SPAN_W = $clog2(MAX_WORDS*MAX_DEPTH+1);

  logic words_ok, depth_ok;
  assign words_ok = (wdata != '0) && (wdata <= TMR_W'(MAX_WORDS));
  assign depth_ok = (wdata != '0) && (wdata <= TMR_W'(MAX_DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      words   <= WPE_W'(1);
      depth   <= CNT_W'(MAX_DEPTH);
      lwm     <= '0;
      hwm     <= CNT_W'(MAX_DEPTH);
      timeout <= '0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        CFG_WORDS:   if (words_ok) words <= WPE_W'(wdata);
        CFG_DEPTH:   if (depth_ok) depth <= CNT_W'(wdata);
        CFG_LWM:     lwm     <= CNT_W'(wdata);
        CFG_HWM:     hwm     <= CNT_W'(wdata);
        CFG_TIMEOUT: timeout <= wdata;
        default:     ;
      endcase
    end
  end

  // Ring span in words; small product, stays combinational
  assign span = SPAN_W'(words) * SPAN_W'(depth);
endmodule

// File: rtl/elem_fifo_ram.sv
module elem_fifo_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/elem_fifo_ptrs.sv
module elem_fifo_ptrs #(
  parameter int MAX_WORDS = 4,
  parameter int MAX_DEPTH = 16
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     push_valid,
  input  logic                                     pop_req,
  input  logic [$clog2(MAX_WORDS+1)-1:0]           words,
  input  logic [$clog2(MAX_DEPTH+1)-1:0]           depth,
  input  logic [$clog2(MAX_WORDS*MAX_DEPTH+1)-1:0] span,
  output logic                                     wr_en,
  output logic [$clog2(MAX_WORDS*MAX_DEPTH)-1:0]   wr_addr,
  output logic                                     rd_en,
  output logic [$clog2(MAX_WORDS*MAX_DEPTH)-1:0]   rd_addr,
  output logic                                     rd_last,
  output logic [$clog2(MAX_DEPTH+1)-1:0]           count,
  output logic [$clog2(MAX_DEPTH+1)-1:0]           count_nxt,
  output logic                                     push_rej,
  output logic                                     pop_rej
);
  localparam int WPE_W  = $clog2(MAX_WORDS+1);
  localparam int CNT_W  = $clog2(MAX_DEPTH+1);
  localparam int PTR_W  = $clog2(MAX_WORDS*MAX_DEPTH);
  localparam int SPAN_W = $clog2(MAX_WORDS*MAX_DEPTH+1);

  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [WPE_W-1:0]  wr_word, rd_word, last_idx;
  logic [SPAN_W-1:0] wr_inc, rd_inc;
  logic              wr_last, commit, release_el;

  assign last_idx   = words - WPE_W'(1);
  assign push_rej   = push_valid && (wr_word == '0) && (count >= depth);
  assign pop_rej    = pop_req && (count == '0);
  assign wr_en      = push_valid && !push_rej;
  assign rd_en      = pop_req && !pop_rej;
  assign wr_last    = (wr_word == last_idx);
  assign rd_last    = (rd_word == last_idx);
  assign commit     = wr_en && wr_last;
  assign release_el = rd_en && rd_last;
  assign wr_addr    = wr_ptr;
  assign rd_addr    = rd_ptr;
  assign wr_inc     = SPAN_W'(wr_ptr) + SPAN_W'(1);
  assign rd_inc     = SPAN_W'(rd_ptr) + SPAN_W'(1);
  assign count_nxt  = count + CNT_W'(commit) - CNT_W'(release_el);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      wr_word <= '0;
      rd_word <= '0;
      count   <= '0;
    end else begin
      count <= count_nxt;
      if (wr_en) begin
        wr_ptr  <= (wr_inc >= span) ? '0 : PTR_W'(wr_inc);
        wr_word <= wr_last ? '0 : wr_word + WPE_W'(1);
      end
      if (rd_en) begin
        rd_ptr  <= (rd_inc >= span) ? '0 : PTR_W'(rd_inc);
        rd_word <= rd_last ? '0 : rd_word + WPE_W'(1);
      end
    end
  end
endmodule

// File: rtl/elem_fifo_events.sv
module elem_fifo_events #(
  parameter int CNT_W = 5,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] count_nxt,
  input  logic [CNT_W-1:0] lwm,
  input  logic [CNT_W-1:0] hwm,
  input  logic [TMR_W-1:0] timeout,
  output logic             not_empty,
  output logic             lwm_evt,
  output logic             hwm_evt,
  output logic             tmr_evt
);
  logic [TMR_W-1:0] tcnt, tcnt_inc;
  logic             armed, hit, hit_n, above;

  assign above    = (count_nxt > hwm);
  assign hit_n    = hit || above;
  assign tcnt_inc = tcnt + TMR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      not_empty <= 1'b0;
      lwm_evt   <= 1'b0;
      hwm_evt   <= 1'b0;
    end else begin
      not_empty <= (count_nxt != '0);
      lwm_evt   <= (count_nxt < lwm);
      hwm_evt   <= above;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || count_nxt == '0) begin
      armed   <= 1'b0;
      hit     <= 1'b0;
      tcnt    <= '0;
      tmr_evt <= 1'b0;
    end else if (count == '0) begin
      armed   <= 1'b1;
      hit     <= above;
      tcnt    <= '0;
      tmr_evt <= 1'b0;
    end else if (armed) begin
      hit <= hit_n;
      if (!tmr_evt && !hit_n) begin
        tcnt <= tcnt_inc;
        if (timeout != '0 && tcnt_inc == timeout) tmr_evt <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/elem_fifo.sv
module elem_fifo
  import elem_fifo_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_WORDS = 4,
  parameter int MAX_DEPTH = 16,
  parameter int TMR_W     = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_we,
  input  logic [CFG_SEL_W-1:0]           cfg_sel,
  input  logic [TMR_W-1:0]               cfg_wdata,
  input  logic                           push_valid,
  input  logic [DATA_W-1:0]              push_data,
  input  logic                           pop_req,
  output logic                           pop_valid,
  output logic [DATA_W-1:0]              pop_data,
  output logic                           pop_last,
  output logic [$clog2(MAX_DEPTH+1)-1:0] elem_count,
  output logic                           not_empty,
  output logic                           lwm_evt,
  output logic                           hwm_evt,
  output logic                           tmr_evt,
  output logic                           push_err,
  output logic                           pop_err
);
  localparam int RAM_WORDS = MAX_WORDS * MAX_DEPTH;
  localparam int WPE_W     = $clog2(MAX_WORDS+1);
  localparam int CNT_W     = $clog2(MAX_DEPTH+1);
  localparam int PTR_W     = $clog2(RAM_WORDS);
  localparam int SPAN_W    = $clog2(RAM_WORDS+1);

  logic [WPE_W-1:0]  cfg_words;
  logic [CNT_W-1:0]  cfg_depth, cfg_lwm, cfg_hwm, count_nxt;
  logic [TMR_W-1:0]  cfg_timeout;
  logic [SPAN_W-1:0] cfg_span;
  logic [PTR_W-1:0]  wr_addr, rd_addr;
  logic              wr_en, rd_en, rd_last, push_rej, pop_rej;

  elem_fifo_cfg #(.MAX_WORDS(MAX_WORDS), .MAX_DEPTH(MAX_DEPTH), .TMR_W(TMR_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .words(cfg_words), .depth(cfg_depth), .lwm(cfg_lwm), .hwm(cfg_hwm),
    .timeout(cfg_timeout), .span(cfg_span)
  );

  elem_fifo_ptrs #(.MAX_WORDS(MAX_WORDS), .MAX_DEPTH(MAX_DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .push_valid(push_valid), .pop_req(pop_req),
    .words(cfg_words), .depth(cfg_depth), .span(cfg_span),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_last(rd_last), .count(elem_count), .count_nxt(count_nxt),
    .push_rej(push_rej), .pop_rej(pop_rej)
  );

  elem_fifo_ram #(.DATA_W(DATA_W), .DEPTH(RAM_WORDS), .ADDR_W(PTR_W)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(push_data),
    .re(rd_en), .raddr(rd_addr), .rdata(pop_data)
  );

  elem_fifo_events #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_evt (
    .clk(clk), .rst(rst), .count(elem_count), .count_nxt(count_nxt),
    .lwm(cfg_lwm), .hwm(cfg_hwm), .timeout(cfg_timeout),
    .not_empty(not_empty), .lwm_evt(lwm_evt), .hwm_evt(hwm_evt), .tmr_evt(tmr_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_valid <= 1'b0;
      pop_last  <= 1'b0;
      push_err  <= 1'b0;
      pop_err   <= 1'b0;
    end else begin
      pop_valid <= rd_en;
      pop_last  <= rd_en && rd_last;
      push_err  <= push_err || push_rej;
      pop_err   <= pop_err || pop_rej;
    end
  end
endmodule

// File: rtl/elem_fifo_chk.sv
module elem_fifo_chk #(
  parameter int MAX_DEPTH = 16,
  parameter int CNT_W     = $clog2(MAX_DEPTH+1)
) (
  input logic             clk,
  input logic             rst,
  input logic             pop_req,
  input logic             pop_valid,
  input logic             push_err,
  input logic             pop_err,
  input logic             not_empty,
  input logic             tmr_evt,
  input logic [CNT_W-1:0] elem_count,
  input logic [CNT_W-1:0] cfg_depth
);
  // R4
  count_in_depth_chk: assert property (@(posedge clk) disable iff (rst)
    elem_count <= cfg_depth);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (elem_count == $past(elem_count)) || (elem_count == $past(elem_count) + 1'b1) ||
    (elem_count + 1'b1 == $past(elem_count)));

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_req && elem_count == '0) |=> (!pop_valid && pop_err));

  // R3
  pop_source_chk: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> ($past(elem_count) != '0));

  // R9
  not_empty_chk: assert property (@(posedge clk) disable iff (rst)
    not_empty == (elem_count != '0));

  // R10
  tmr_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_evt |-> not_empty);

  // R4
  push_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    push_err |=> push_err);

  // R5
  pop_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    pop_err |=> pop_err);
endmodule

bind elem_fifo elem_fifo_chk #(.MAX_DEPTH(MAX_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .pop_req(pop_req), .pop_valid(pop_valid),
  .push_err(push_err), .pop_err(pop_err), .not_empty(not_empty),
  .tmr_evt(tmr_evt), .elem_count(elem_count), .cfg_depth(cfg_depth)
);

// File: tb/elem_fifo_bench.sv
module elem_fifo_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [15:0] cfg_wdata;
  logic        push_valid;
  logic [31:0] push_data;
  logic        pop_req;
  logic        pop_valid;
  logic [31:0] pop_data;
  logic        pop_last;
  logic [4:0]  elem_count;
  logic        not_empty, lwm_evt, hwm_evt, tmr_evt, push_err, pop_err;

  int n_chk  = 0;
  int n_fail = 0;
  int cur_words = 1;
  int exp_q[$];

  always #5 clk = ~clk;

  elem_fifo u_elem_fifo (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .push_valid(push_valid), .push_data(push_data), .pop_req(pop_req),
    .pop_valid(pop_valid), .pop_data(pop_data), .pop_last(pop_last),
    .elem_count(elem_count), .not_empty(not_empty), .lwm_evt(lwm_evt),
    .hwm_evt(hwm_evt), .tmr_evt(tmr_evt), .push_err(push_err), .pop_err(pop_err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input int id, input int w);
    return 32'hE000_0000 | (32'(id) << 8) | 32'(w);
  endfunction

  task automatic cfg_wr(input logic [2:0] s, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic push_word(input logic [31:0] d);
    @(negedge clk);
    push_valid = 1'b1; push_data = d;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic pop_word(output logic v, output logic l, output logic [31:0] d);
    @(negedge clk);
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
    v = pop_valid; l = pop_last; d = pop_data;
  endtask

  task automatic push_elem(input int id);
    for (int w = 0; w < cur_words; w++) push_word(word_of(id, w));
    exp_q.push_back(id);
  endtask

  task automatic pop_elem(input string req);
    logic v, l;
    logic [31:0] d;
    int id;
    id = exp_q.pop_front();
    for (int w = 0; w < cur_words; w++) begin
      pop_word(v, l, d);
      chk(req, "pop_valid", 32'(v), 1);
      chk(req, "pop_data", d, word_of(id, w));
      chk(req, "pop_last", 32'(l), 32'(w == cur_words - 1));
    end
  endtask

  task automatic t_reset;
    chk("R1", "elem_count", 32'(elem_count), 0);
    chk("R1", "not_empty", 32'(not_empty), 0);
    chk("R1", "lwm_evt", 32'(lwm_evt), 0);
    chk("R1", "hwm_evt", 32'(hwm_evt), 0);
    chk("R1", "tmr_evt", 32'(tmr_evt), 0);
    chk("R1", "errors", {30'd0, push_err, pop_err}, 0);
    chk("R1", "pop_valid", 32'(pop_valid), 0);
  endtask

  task automatic t_commit;
    cfg_wr(3'd0, 3); cur_words = 3;
    cfg_wr(3'd1, 4);
    cfg_wr(3'd2, 2);
    cfg_wr(3'd3, 3);
    chk("R7", "lwm_evt at empty", 32'(lwm_evt), 1);
    push_word(word_of(0, 0));
    push_word(word_of(0, 1));
    chk("R2", "count after partial element", 32'(elem_count), 0);
    chk("R9", "not_empty after partial element", 32'(not_empty), 0);
    push_word(word_of(0, 2));
    exp_q.push_back(0);
    chk("R2", "count after last word", 32'(elem_count), 1);
    chk("R9", "not_empty after commit", 32'(not_empty), 1);
    chk("R7", "lwm_evt at 1 of 2", 32'(lwm_evt), 1);
  endtask

  task automatic t_full;
    push_elem(1);
    chk("R7", "lwm_evt at 2 of 2", 32'(lwm_evt), 0);
    push_elem(2);
    chk("R8", "hwm_evt at 3 of 3", 32'(hwm_evt), 0);
    push_elem(3);
    chk("R8", "hwm_evt at 4 of 3", 32'(hwm_evt), 1);
    chk("R4", "push_err before overflow", 32'(push_err), 0);
    for (int w = 0; w < 3; w++) push_word(word_of(99, w));
    chk("R4", "push_err after overflow", 32'(push_err), 1);
    chk("R4", "count after overflow", 32'(elem_count), 4);
  endtask

  task automatic t_drain;
    logic v, l;
    logic [31:0] d;
    int id;
    id = exp_q.pop_front();
    pop_word(v, l, d);
    chk("R3", "first word", d, word_of(id, 0));
    pop_word(v, l, d);
    chk("R3", "second word last flag", 32'(l), 0);
    chk("R3", "count during partial pop", 32'(elem_count), 4);
    pop_word(v, l, d);
    chk("R3", "third word", d, word_of(id, 2));
    chk("R3", "pop_last on final word", 32'(l), 1);
    chk("R3", "count after element read", 32'(elem_count), 3);
    pop_elem("R4");
    pop_elem("R4");
    chk("R7", "lwm_evt at 1", 32'(lwm_evt), 1);
    pop_elem("R4");
    chk("R9", "not_empty after drain", 32'(not_empty), 0);
    chk("R4", "count after drain", 32'(elem_count), 0);
  endtask

  task automatic t_underflow;
    logic v, l;
    logic [31:0] d;
    chk("R5", "pop_err before", 32'(pop_err), 0);
    pop_word(v, l, d);
    chk("R5", "pop_valid on empty", 32'(v), 0);
    chk("R5", "pop_err after", 32'(pop_err), 1);
    chk("R5", "count stays 0", 32'(elem_count), 0);
  endtask

  task automatic t_cfg_reject;
    cfg_wr(3'd0, 0);
    cfg_wr(3'd0, 7);
    push_word(word_of(5, 0));
    push_word(word_of(5, 1));
    chk("R6", "ignored words value keeps 3", 32'(elem_count), 0);
    push_word(word_of(5, 2));
    exp_q.push_back(5);
    chk("R6", "commit at third word", 32'(elem_count), 1);
    pop_elem("R6");
    cfg_wr(3'd1, 0);
    cfg_wr(3'd1, 17);
    for (int e = 0; e < 4; e++) push_elem(6 + e);
    for (int w = 0; w < 3; w++) push_word(word_of(98, w));
    chk("R6", "ignored depth values keep 4", 32'(elem_count), 4);
    for (int e = 0; e < 4; e++) pop_elem("R6");
  endtask

  task automatic t_wrap;
    cfg_wr(3'd1, 5);
    for (int r = 0; r < 5; r++) begin
      for (int e = 0; e < 4; e++) push_elem(16 + r * 8 + e);
      pop_elem("R13");
      pop_elem("R13");
      for (int e = 4; e < 7; e++) push_elem(16 + r * 8 + e);
      chk("R13", "count at depth", 32'(elem_count), 5);
      for (int e = 0; e < 5; e++) pop_elem("R13");
    end
    chk("R13", "count after wraps", 32'(elem_count), 0);
  endtask

  task automatic t_timer;
    cfg_wr(3'd0, 1); cur_words = 1;
    cfg_wr(3'd1, 16);
    cfg_wr(3'd3, 8);
    cfg_wr(3'd4, 20);
    push_elem(100);
    repeat (19) @(negedge clk);
    chk("R10", "tmr_evt one tick early", 32'(tmr_evt), 0);
    @(negedge clk);
    chk("R10", "tmr_evt at expiry", 32'(tmr_evt), 1);
    push_elem(101);
    chk("R10", "tmr_evt holds", 32'(tmr_evt), 1);
    pop_elem("R12");
    chk("R10", "tmr_evt holds while nonempty", 32'(tmr_evt), 1);
    pop_elem("R12");
    chk("R12", "tmr_evt clears on empty", 32'(tmr_evt), 0);
  endtask

  task automatic t_restart;
    push_elem(110);
    repeat (10) @(negedge clk);
    pop_elem("R12");
    push_elem(111);
    repeat (19) @(negedge clk);
    chk("R12", "restarted timer one tick early", 32'(tmr_evt), 0);
    @(negedge clk);
    chk("R12", "restarted timer at expiry", 32'(tmr_evt), 1);
    pop_elem("R12");
  endtask

  task automatic t_hwm_suppress;
    cfg_wr(3'd3, 2);
    for (int e = 0; e < 3; e++) push_elem(120 + e);
    chk("R8", "hwm_evt at 3 of 2", 32'(hwm_evt), 1);
    repeat (30) @(negedge clk);
    chk("R11", "timer suppressed by hwm", 32'(tmr_evt), 0);
    pop_elem("R11");
    chk("R8", "hwm_evt at 2 of 2", 32'(hwm_evt), 0);
    repeat (30) @(negedge clk);
    chk("R11", "still suppressed below hwm", 32'(tmr_evt), 0);
    pop_elem("R11");
    pop_elem("R11");
  endtask

  task automatic t_zero_timeout;
    cfg_wr(3'd4, 0);
    push_elem(130);
    repeat (40) @(negedge clk);
    chk("R10", "zero timeout never fires", 32'(tmr_evt), 0);
    pop_elem("R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    push_valid = 1'b0; push_data = '0; pop_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_commit();
    t_full();
    t_drain();
    t_underflow();
    t_cfg_reject();
    t_wrap();
    t_timer();
    t_restart();
    t_hwm_suppress();
    t_zero_timeout();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule